// File: doc/BRIEF.md
# Test Access Path Router

This block sits at a bidirectional test access point on a serial line whose two sides are called E and F. Each side has an incoming and an outgoing bit stream, and each stream is a bundle of parallel lanes: the two transmission paths of the line, with room for more. A two-bit mode command chooses how these four streams connect to four other points. One is the input of a performance detector. One is the output of a test pattern generator. The others are a loopback path and an internal quasi-random fill source. Any stream that is left unused is treated as terminated, which here means it is ignored.

The mode command is latched on every clock edge. The routing that follows from it is registered, so the outputs switch between modes in one clean step and never show a mix of two modes. When the router drops back to pass-through, it raises a one-cycle stop pulse that ends any measurement in progress. A detector-valid flag tells the detector whether it is being fed a real stream.

Top module: `tap_router`

## Requirements
- R1: `mode_cmd` is latched on every rising clock edge. The code latched at edge k controls the outputs from edge k+1 on. Encoding: 2'b00 pass-through, 2'b01 split toward F, 2'b10 loop on E, 2'b11 loop on F.
- R2: Every routed output is registered. After an edge it holds the value that its source input (or the fill bit) had just before that edge.
- R3: In pass-through, `f_out` carries `e_in` and `e_out` carries `f_in`. `spd_data` holds the idle level `IDLE_LVL` on every lane, and `spd_valid` is 0.
- R4: In split toward F, `spd_data` carries `f_in`, `f_out` carries `tsg_in`, and `e_out` loops `e_in` back.
- R5: In loop on E, both `spd_data` and `e_out` carry `e_in`, and `f_out` carries the fill bit on every lane. `f_in` affects no output.
- R6: In loop on F, both `spd_data` and `f_out` carry `f_in`, and `e_out` carries the fill bit on every lane. `e_in` affects no output.
- R7: All lanes follow the same mode at the same time.
- R8: `meas_stop` is high for exactly the first cycle in which the outputs show pass-through after they showed another mode. It stays low through reset and while pass-through is held.
- R9: The fill source is a 20-stage register with stages s1..s20, seeded with all ones at reset and advanced on every clock. The new s1 is s17 XOR s20, and each other stage takes the value of the stage below it. The fill bit is s20 OR'd with the condition that stages s6 through s19 are all 0. As a result, the fill never contains more than 14 consecutive zeros.
- R10: `spd_valid` is 1 exactly in the modes that route a stream to the detector: split and both loops.
- R11: While `rst_n` is low (asynchronous, active low), the mode is pass-through, `e_out`, `f_out` and `spd_data` hold `IDLE_LVL` on every lane, and `spd_valid` and `meas_stop` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_cmd | input | 2 | Requested routing mode |
| e_in | input | LANES | Stream arriving from side E |
| f_in | input | LANES | Stream arriving from side F |
| tsg_in | input | LANES | Test pattern generator output |
| e_out | output | LANES | Stream leaving toward side E |
| f_out | output | LANES | Stream leaving toward side F |
| spd_data | output | LANES | Stream fed to the performance detector |
| spd_valid | output | 1 | Detector is being fed a routed stream |
| meas_stop | output | 1 | One-cycle measurement abort pulse |

## Verification
On every cycle, the assertions check the following: the routing of the current mode against the inputs of the previous cycle, the idle detector value whenever valid is low, the single-cycle width of the stop pulse and that it appears only on entry to pass-through, and that the fill register never collapses to all zeros and never emits a run of more than 14 zeros. Only the bench's scenarios can show the remaining behaviour. That covers the two-edge mode latency, back-to-back mode changes one cycle apart, the exact fill sequence from the seed, and recovery after a reset in the middle of a run.

// File: rtl/tap_pkg.sv
package tap_pkg;
  typedef enum logic [1:0] {
    TAP_THRU    = 2'b00,
    TAP_SPLIT_F = 2'b01,
    TAP_LOOP_E  = 2'b10,
    TAP_LOOP_F  = 2'b11
  } tap_mode_e;

  localparam int QRS_LEN  = 20;
  localparam int QRS_TAP  = 17;
  localparam int ZERO_MAX = 14;

  // stage k of the fill register lives in bit k-1
  function automatic logic [QRS_LEN-1:0] qrs_advance(input logic [QRS_LEN-1:0] s);
    return {s[QRS_LEN-2:0], s[QRS_TAP-1] ^ s[QRS_LEN-1]};
  endfunction

  function automatic logic qrs_emit(input logic [QRS_LEN-1:0] s);
    return s[QRS_LEN-1] | ~(|s[QRS_LEN-2:QRS_LEN-1-ZERO_MAX]);
  endfunction

  function automatic logic feeds_detector(input tap_mode_e m);
    return m != TAP_THRU;
  endfunction
endpackage

// File: rtl/tap_mode_ctrl.sv
module tap_mode_ctrl
  import tap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  tap_mode_e mode_req,
  output tap_mode_e sel_mode,
  output tap_mode_e act_mode,
  output logic      meas_stop,
  output logic      spd_valid
);
  logic stop_evt;
  assign stop_evt = (sel_mode == TAP_THRU) && (act_mode != TAP_THRU);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_mode  <= TAP_THRU;
      act_mode  <= TAP_THRU;
      meas_stop <= 1'b0;
      spd_valid <= 1'b0;
    end else begin
      sel_mode  <= mode_req;
      act_mode  <= sel_mode;
      meas_stop <= stop_evt;
      spd_valid <= feeds_detector(sel_mode);
    end
  end

  // R8: the abort pulse lasts one cycle
  p_stop_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    meas_stop |=> !meas_stop);
  // R8: the pulse marks entry into pass-through only
  p_stop_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    meas_stop |-> (act_mode == TAP_THRU && $past(act_mode) != TAP_THRU));
  // R10: valid tracks the mode shown at the outputs
  p_valid_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    spd_valid == (act_mode != TAP_THRU));
endmodule

// File: rtl/tap_qrs_gen.sv
module tap_qrs_gen
  import tap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic fill_bit
);
  logic [QRS_LEN-1:0] state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= '1;
    else        state <= qrs_advance(state);
  end

  assign fill_bit = qrs_emit(state);

  // checker: length of the current run of zeros in the fill
  logic [4:0] zrun;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        zrun <= '0;
    else if (fill_bit) zrun <= '0;
    else               zrun <= zrun + 5'd1;
  end

  p_zero_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    zrun <= 5'(ZERO_MAX));
  p_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    |state);
endmodule

// File: rtl/tap_xbar.sv
module tap_xbar
  import tap_pkg::*;
#(
  parameter int   LANES    = 2,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tap_mode_e        sel,
  input  logic [LANES-1:0] e_in,
  input  logic [LANES-1:0] f_in,
  input  logic [LANES-1:0] tsg_in,
  input  logic             fill_bit,
  output logic [LANES-1:0] e_out,
  output logic [LANES-1:0] f_out,
  output logic [LANES-1:0] spd_data
);
  logic [LANES-1:0] e_nxt, f_nxt, d_nxt;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      unique case (sel)
        TAP_SPLIT_F: begin e_nxt[g] = e_in[g];   f_nxt[g] = tsg_in[g]; d_nxt[g] = f_in[g];   end
        TAP_LOOP_E:  begin e_nxt[g] = e_in[g];   f_nxt[g] = fill_bit;  d_nxt[g] = e_in[g];   end
        TAP_LOOP_F:  begin e_nxt[g] = fill_bit;  f_nxt[g] = f_in[g];   d_nxt[g] = f_in[g];   end
        default:     begin e_nxt[g] = f_in[g];   f_nxt[g] = e_in[g];   d_nxt[g] = IDLE_LVL;  end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_out    <= {LANES{IDLE_LVL}};
      f_out    <= {LANES{IDLE_LVL}};
      spd_data <= {LANES{IDLE_LVL}};
    end else begin
      e_out    <= e_nxt;
      f_out    <= f_nxt;
      spd_data <= d_nxt;
    end
  end
endmodule

// File: rtl/tap_router.sv
module tap_router
  import tap_pkg::*;
#(
  parameter int   LANES    = 2,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_cmd,
  input  logic [LANES-1:0] e_in,
  input  logic [LANES-1:0] f_in,
  input  logic [LANES-1:0] tsg_in,
  output logic [LANES-1:0] e_out,
  output logic [LANES-1:0] f_out,
  output logic [LANES-1:0] spd_data,
  output logic             spd_valid,
  output logic             meas_stop
);
  tap_mode_e sel_mode, act_mode;
  logic      fill_bit;

  tap_mode_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_req(tap_mode_e'(mode_cmd)),
    .sel_mode(sel_mode), .act_mode(act_mode),
    .meas_stop(meas_stop), .spd_valid(spd_valid)
  );

  tap_qrs_gen u_qrs (.clk(clk), .rst_n(rst_n), .fill_bit(fill_bit));

  tap_xbar #(.LANES(LANES), .IDLE_LVL(IDLE_LVL)) u_xbar (
    .clk(clk), .rst_n(rst_n), .sel(sel_mode),
    .e_in(e_in), .f_in(f_in), .tsg_in(tsg_in), .fill_bit(fill_bit),
    .e_out(e_out), .f_out(f_out), .spd_data(spd_data)
  );

  // checker: one edge has passed since reset, so $past of the inputs is meaningful
  logic primed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= 1'b1;
  end

  p_thru_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && act_mode == TAP_THRU) |-> (f_out == $past(e_in) && e_out == $past(f_in)));
  p_split_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && act_mode == TAP_SPLIT_F) |->
      (spd_data == $past(f_in) && f_out == $past(tsg_in) && e_out == $past(e_in)));
  p_loop_e_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && act_mode == TAP_LOOP_E) |->
      (spd_data == $past(e_in) && e_out == $past(e_in) && f_out == {LANES{$past(fill_bit)}}));
  p_loop_f_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && act_mode == TAP_LOOP_F) |->
      (spd_data == $past(f_in) && f_out == $past(f_in) && e_out == {LANES{$past(fill_bit)}}));
  p_idle_detector_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !spd_valid |-> spd_data == {LANES{IDLE_LVL}});
endmodule

// File: tb/tb_tap_router.sv
module tb_tap_router;
  localparam int   LANES = 2;
  localparam logic IDLE  = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_cmd = 2'b00;
  logic [LANES-1:0] e_in = '0, f_in = '0, tsg_in = '0;
  logic [LANES-1:0] e_out, f_out, spd_data;
  logic spd_valid, meas_stop;

  int errors = 0;
  int checks = 0;

  tap_router #(.LANES(LANES), .IDLE_LVL(IDLE)) dut (
    .clk(clk), .rst_n(rst_n), .mode_cmd(mode_cmd),
    .e_in(e_in), .f_in(f_in), .tsg_in(tsg_in),
    .e_out(e_out), .f_out(f_out), .spd_data(spd_data),
    .spd_valid(spd_valid), .meas_stop(meas_stop)
  );

  always #10 clk = ~clk;

  // reference model: mode pipeline as integers, fill source as a bit queue (q[0] is stage 1)
  int m_sel, m_act;
  bit q[$];
  logic [LANES-1:0] x_e, x_f, x_spd;
  logic x_v, x_stop;

  function automatic bit fill_now();
    bit quiet = 1'b1;
    for (int k = 5; k <= 18; k++) if (q[k]) quiet = 1'b0;
    return q[19] | quiet;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_act = 0;
      q.delete();
      for (int k = 0; k < 20; k++) q.push_back(1'b1);
      x_e = {LANES{IDLE}}; x_f = {LANES{IDLE}}; x_spd = {LANES{IDLE}};
      x_v = 1'b0; x_stop = 1'b0;
    end else begin
      bit fb;
      fb = fill_now();
      x_stop = (m_sel == 0) && (m_act != 0);
      x_v = (m_sel != 0);
      case (m_sel)
        1: begin x_spd = f_in; x_f = tsg_in; x_e = e_in; end
        2: begin x_spd = e_in; x_e = e_in; x_f = {LANES{fb}}; end
        3: begin x_spd = f_in; x_f = f_in; x_e = {LANES{fb}}; end
        default: begin x_e = f_in; x_f = e_in; x_spd = {LANES{IDLE}}; end
      endcase
      m_act = m_sel;
      m_sel = int'(mode_cmd);
      q.push_front(q[16] ^ q[19]);
      void'(q.pop_back());
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string t;
    if (!rst_n) t = "R11";
    else case (m_act)
      1: t = "R1 R2 R7 R4";
      2: t = "R1 R2 R7 R5 R9";
      3: t = "R1 R2 R7 R6 R9";
      default: t = "R1 R2 R7 R3";
    endcase
    chk({t, " e_out"}, 8'(e_out), 8'(x_e));
    chk({t, " f_out"}, 8'(f_out), 8'(x_f));
    chk({t, " spd_data"}, 8'(spd_data), 8'(x_spd));
    chk({t, " R10 spd_valid"}, 8'(spd_valid), 8'(x_v));
    chk({t, " R8 meas_stop"}, 8'(meas_stop), 8'(x_stop));
  endtask

  task automatic step(input logic [1:0] m);
    @(negedge clk);
    compare_all();
    mode_cmd = m;
    e_in   = LANES'($urandom);
    f_in   = LANES'($urandom);
    tsg_in = LANES'($urandom);
  endtask

  task automatic run(input logic [1:0] m, input int n);
    for (int i = 0; i < n; i++) step(m);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    run(2'b00, 3);               // R11 reset values
    @(negedge clk); rst_n = 1'b1;
    run(2'b00, 5);               // R3 pass-through
    run(2'b01, 12);              // R4 split toward F
    run(2'b00, 6);               // R8 stop pulse, then held low
    run(2'b10, 1200);            // R5 R9 long fill run
    run(2'b11, 40);              // R6 direct loop change
    run(2'b00, 1);               // R8 single-cycle visits
    run(2'b10, 1);
    run(2'b00, 1);
    run(2'b01, 1);
    run(2'b11, 1);
    run(2'b00, 8);
    run(2'b11, 20);
    @(negedge clk); compare_all(); rst_n = 1'b0;   // R11 reset mid-run
    run(2'b10, 3);
    @(negedge clk); rst_n = 1'b1;
    run(2'b10, 300);             // R9 fill restarts from seed
    run(2'b00, 5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule